// File: doc/BRIEF.md
# BCH error-position bit corrector

This block finishes a BCH decode by repairing the data buffer in place. A decoder has already found the error positions and left them in a small array of 32-bit index words, two positions per word, along with an error count and three result flags. After a start pulse the corrector walks the reported errors in order. For each one it reads the byte that holds the bad bit, inverts that single bit and writes the byte back. A done pulse then reports whether the data can be trusted.

Each position is a bit offset into the protected data. Its upper bits select a byte and its low three bits select a bit within that byte. A position that falls past the configured data length lies in the parity bytes and is skipped, so the data region is never touched for it. If the decoder flags the page as entirely 0x00 or entirely 0xFF, or as uncorrectable, the buffer is not accessed at all. In the last case the done pulse carries a bad-message indication.

Top module: `bch_bitfix`

## Requirements
- R1: Index word k holds error number 2k in bits 12:0 and error number 2k+1 in bits 28:16. Error number i is read from word address i/2. The bits outside these two fields are ignored.
- R2: The index port is a synchronous read port. Its data is taken on the cycle after `idx_rd_en` is high. The word is fetched only for even error numbers, so one run makes (count+1)/2 index reads.
- R3: On a start with no flags set, exactly `err_count` errors (0 to 15) are processed, in ascending error number.
- R4: Position p inverts only bit (p mod 8) of byte address (p >> 3). The other seven bits of that byte keep their value.
- R5: If `flag_all00` or `flag_allff` is set at start, the buffer is not accessed and done comes with `bad_msg` = 0. This holds even when `flag_uncor` is also set.
- R6: If only `flag_uncor` is set at start, the buffer is not accessed and done comes with `bad_msg` = 1.
- R7: A start with `err_count` = 0 and no flags raises done on the first clock edge after the start edge, with `bad_msg` = 0 and no buffer or index access.
- R8: Each correction is a read followed by a write to the same byte address. A request is held, with its address stable, until `buf_ack`. The next error is not begun until the write has been acknowledged.
- R9: A position whose byte address is at or above `data_len` (sampled at start) causes no buffer access.
- R10: After the last correction, done is a single-cycle pulse with `bad_msg` = 0.
- R11: While reset is asserted, `done`, `buf_req` and `idx_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to apply corrections; taken only when idle |
| err_count | input | 4 | Number of reported errors |
| flag_all00 | input | 1 | Decode found data and parity all 0x00 |
| flag_allff | input | 1 | Decode found data and parity all 0xFF |
| flag_uncor | input | 1 | Decode found the page uncorrectable |
| data_len | input | 11 | Number of data bytes; byte addresses at or above it are skipped |
| idx_rd_en | output | 1 | Index word read strobe |
| idx_rd_addr | output | 3 | Index word address |
| idx_rd_data | input | 32 | Index word, valid the cycle after the strobe |
| buf_req | output | 1 | Buffer access request, held until acknowledged |
| buf_we | output | 1 | 1 = write, 0 = read |
| buf_addr | output | 10 | Buffer byte address |
| buf_wdata | output | 8 | Byte to write |
| buf_rdata | input | 8 | Byte read, valid with `buf_ack` |
| buf_ack | input | 1 | Buffer accepts the current request |
| done | output | 1 | One-cycle completion pulse |
| bad_msg | output | 1 | With done: 1 = data uncorrectable |

## Verification
The bench builds the block with its default parameters: 13-bit positions, a high field at bit 16, 32-bit index words and a 4-bit count. This gives a 1024-byte address space, up to 15 errors and eight index words. A count of 15 reaches the last word, where only the low half is used. Data lengths of 512 and 64 bytes put some positions past the end, including the last in-range byte and the top address 1023. The buffer model varies its acknowledge delay from zero to two cycles, which stretches both halves of each read-modify-write.

// File: rtl/bitfix_pkg.sv
// Package: shared state encodings and the start-time verdict for the
// bit corrector. Assumes nothing beyond IEEE 1800-2017 synthesizable types.
package bitfix_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        C_IDLE,
        C_FETCH,
        C_LATCH,
        C_EVAL,
        C_WAIT,
        C_NEXT
    } ctl_state_t;

    typedef enum logic [1:0] {
        M_IDLE,
        M_READ,
        M_WRITE
    } rmw_state_t;

    typedef enum logic [1:0] {
        V_RUN,
        V_CLEAN,
        V_BAD
    } verdict_t;

    // Decide at start what a run does; blank flags outrank the uncorrectable flag.
    function automatic verdict_t judge(input logic all00, input logic allff,
                                       input logic uncor, input logic cnt_zero);
        verdict_t v;
        if (all00 || allff)
            v = V_CLEAN;
        else if (uncor)
            v = V_BAD;
        else if (cnt_zero)
            v = V_CLEAN;
        else
            v = V_RUN;
        return v;
    endfunction

endpackage

// File: rtl/bitfix_locate.sv
// Module: selects one packed position from an index word and turns it into
// a byte address, a one-hot bit mask and an in-range indication.
// Assumes: the high field does not overlap the low field and fits in the word.
module bitfix_locate #(
    parameter int IDX_W  = 32,
    parameter int POS_W  = 13,
    parameter int HI_LSB = 16
) (
    input  logic [IDX_W-1:0] word,
    input  logic             sel_hi,
    input  logic [POS_W-3:0] len,
    output logic [POS_W-4:0] byte_addr,
    output logic [7:0]       mask,
    output logic             in_range
);

    localparam int LEN_W = POS_W - 2;

    logic [POS_W-1:0] pos;
    logic             unused_word;

    // Pick the low or high position field of the fetched word.
    assign pos = sel_hi ? word[HI_LSB +: POS_W] : word[POS_W-1:0];

    // Byte address is the position without its bit-in-byte part.
    assign byte_addr = pos[POS_W-1:3];

    // One-hot mask selecting the bit inside the byte.
    generate
        for (genvar g = 0; g < 8; g++) begin : g_mask
            assign mask[g] = (pos[2:0] == 3'(g));
        end
    endgenerate

    // Positions past the data length fall in parity and are skipped.
    assign in_range = (LEN_W'(byte_addr) < len);

    // Bits outside both fields carry no meaning.
    assign unused_word = ^word;

endmodule

// File: rtl/bitfix_rmw.sv
// Module: performs one read-modify-write on the byte buffer: read the byte,
// invert the masked bit, write it back. Assumes the buffer returns read data
// in the cycle it acknowledges, and that go is only raised while idle.
module bitfix_rmw
    import bitfix_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] mask,
    output logic              fin,
    output logic              buf_req,
    output logic              buf_we,
    output logic [AW-1:0]     buf_addr,
    output logic [BYTE_W-1:0] buf_wdata,
    input  logic              buf_ack,
    input  logic [BYTE_W-1:0] buf_rdata
);

    rmw_state_t        st;
    logic [AW-1:0]     addr_q;
    logic [BYTE_W-1:0] mask_q;
    logic [BYTE_W-1:0] byte_q;

    // Sequence read then write, holding each request until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= M_IDLE;
            addr_q <= '0;
            mask_q <= '0;
            byte_q <= '0;
        end else begin
            case (st)
                M_IDLE: begin
                    if (go) begin
                        addr_q <= addr;
                        mask_q <= mask;
                        st     <= M_READ;
                    end
                end
                M_READ: begin
                    if (buf_ack) begin
                        byte_q <= buf_rdata ^ mask_q;
                        st     <= M_WRITE;
                    end
                end
                M_WRITE: begin
                    if (buf_ack)
                        st <= M_IDLE;
                end
                default: st <= M_IDLE;
            endcase
        end
    end

    // Drive the buffer port from the current step.
    assign buf_req   = (st != M_IDLE);
    assign buf_we    = (st == M_WRITE);
    assign buf_addr  = addr_q;
    assign buf_wdata = byte_q;
    assign fin       = (st == M_WRITE) && buf_ack;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_req && !buf_ack) |=> (buf_req && $stable(buf_addr) && $stable(buf_we))); // R8
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_we) |-> $past(buf_req && buf_ack && !buf_we)); // R8
    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !buf_req); // R8

endmodule

// File: rtl/bitfix_ctrl.sv
// Module: run controller. Decides at start whether corrections apply, steps
// through the error numbers, fetches an index word on each even number and
// hands in-range positions to the read-modify-write engine.
// Assumes the index port has one cycle of read latency.
module bitfix_ctrl
    import bitfix_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int IDX_W = 32,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] err_count,
    input  logic             all00,
    input  logic             allff,
    input  logic             uncor,
    input  logic [LEN_W-1:0] data_len,
    output logic             idx_rd_en,
    output logic [CNT_W-2:0] idx_rd_addr,
    input  logic [IDX_W-1:0] idx_rd_data,
    output logic [IDX_W-1:0] word,
    output logic             sel_hi,
    output logic [LEN_W-1:0] len,
    input  logic             in_range,
    output logic             rmw_go,
    input  logic             rmw_fin,
    output logic             done,
    output logic             bad_msg
);

    ctl_state_t       st;
    logic [CNT_W-1:0] num_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] num_nx;
    logic [IDX_W-1:0] word_q;
    logic [LEN_W-1:0] len_q;
    logic             done_q;
    logic             bad_q;
    verdict_t         verdict;

    // Start-time decision from the flags and the count.
    assign verdict = judge(all00, allff, uncor, (err_count == '0));

    // Next error number.
    assign num_nx = num_q + 1'b1;

    // Main sequencer for one correction run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= C_IDLE;
            num_q  <= '0;
            cnt_q  <= '0;
            word_q <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                C_IDLE: begin
                    if (start) begin
                        cnt_q <= err_count;
                        len_q <= data_len;
                        num_q <= '0;
                        case (verdict)
                            V_RUN: st <= C_FETCH;
                            V_BAD: begin
                                done_q <= 1'b1;
                                bad_q  <= 1'b1;
                            end
                            default: begin
                                done_q <= 1'b1;
                                bad_q  <= 1'b0;
                            end
                        endcase
                    end
                end
                C_FETCH: st <= C_LATCH;
                C_LATCH: begin
                    word_q <= idx_rd_data;
                    st     <= C_EVAL;
                end
                C_EVAL: st <= in_range ? C_WAIT : C_NEXT;
                C_WAIT: begin
                    if (rmw_fin)
                        st <= C_NEXT;
                end
                C_NEXT: begin
                    num_q <= num_nx;
                    if (num_nx == cnt_q) begin
                        st     <= C_IDLE;
                        done_q <= 1'b1;
                        bad_q  <= 1'b0;
                    end else if (!num_nx[0]) begin
                        st <= C_FETCH;
                    end else begin
                        st <= C_EVAL;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    // Index port and hand-off to the locate and rmw stages.
    assign idx_rd_en   = (st == C_FETCH);
    assign idx_rd_addr = num_q[CNT_W-1:1];
    assign word        = word_q;
    assign sel_hi      = num_q[0];
    assign len         = len_q;
    assign rmw_go      = (st == C_EVAL) && in_range;
    assign done        = done_q;
    assign bad_msg     = bad_q;

    AST_FETCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        idx_rd_en |-> !num_q[0]); // R2
    AST_NUM_BELOW_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st != C_IDLE) |-> (num_q < cnt_q)); // R3
    AST_CLEAN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_IDLE && start && (all00 || allff)) |=> (done && !bad_msg && st == C_IDLE)); // R5
    AST_BAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_IDLE && start && uncor && !all00 && !allff) |=> (done && bad_msg && st == C_IDLE)); // R6
    AST_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_IDLE && start && err_count == '0) |=> (done && st == C_IDLE)); // R7

endmodule

// File: rtl/bch_bitfix.sv
// Module: top of the BCH error-position bit corrector. Connects the run
// controller, the position decoder and the read-modify-write engine.
// Assumes start is raised only while no run is in progress, that data_len
// is valid at start, and that index words stay unchanged during a run.
module bch_bitfix #(
    parameter int POS_W  = 13,
    parameter int HI_LSB = 16,
    parameter int IDX_W  = 32,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] err_count,
    input  logic             flag_all00,
    input  logic             flag_allff,
    input  logic             flag_uncor,
    input  logic [POS_W-3:0] data_len,
    output logic             idx_rd_en,
    output logic [CNT_W-2:0] idx_rd_addr,
    input  logic [IDX_W-1:0] idx_rd_data,
    output logic             buf_req,
    output logic             buf_we,
    output logic [POS_W-4:0] buf_addr,
    output logic [7:0]       buf_wdata,
    input  logic [7:0]       buf_rdata,
    input  logic             buf_ack,
    output logic             done,
    output logic             bad_msg
);

    localparam int BYTE_AW = POS_W - 3;
    localparam int LEN_W   = POS_W - 2;

    logic [IDX_W-1:0]   word;
    logic               sel_hi;
    logic [LEN_W-1:0]   len;
    logic [BYTE_AW-1:0] loc_addr;
    logic [7:0]         loc_mask;
    logic               in_range;
    logic               rmw_go;
    logic               rmw_fin;

    bitfix_ctrl #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W),
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .err_count   (err_count),
        .all00       (flag_all00),
        .allff       (flag_allff),
        .uncor       (flag_uncor),
        .data_len    (data_len),
        .idx_rd_en   (idx_rd_en),
        .idx_rd_addr (idx_rd_addr),
        .idx_rd_data (idx_rd_data),
        .word        (word),
        .sel_hi      (sel_hi),
        .len         (len),
        .in_range    (in_range),
        .rmw_go      (rmw_go),
        .rmw_fin     (rmw_fin),
        .done        (done),
        .bad_msg     (bad_msg)
    );

    bitfix_locate #(
        .IDX_W  (IDX_W),
        .POS_W  (POS_W),
        .HI_LSB (HI_LSB)
    ) u_locate (
        .word      (word),
        .sel_hi    (sel_hi),
        .len       (len),
        .byte_addr (loc_addr),
        .mask      (loc_mask),
        .in_range  (in_range)
    );

    bitfix_rmw #(
        .AW (BYTE_AW)
    ) u_rmw (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (rmw_go),
        .addr      (loc_addr),
        .mask      (loc_mask),
        .fin       (rmw_fin),
        .buf_req   (buf_req),
        .buf_we    (buf_we),
        .buf_addr  (buf_addr),
        .buf_wdata (buf_wdata),
        .buf_ack   (buf_ack),
        .buf_rdata (buf_rdata)
    );

    AST_ADDR_IN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req |-> (LEN_W'(buf_addr) < len)); // R9
    AST_ONE_BIT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_go |-> $onehot(loc_mask)); // R4
    AST_NO_ACCESS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!buf_req && !idx_rd_en)); // R10

endmodule

// File: tb/bch_bitfix_tb.sv
`timescale 1ns/1ps
module bch_bitfix_tb;

    typedef struct packed {
        logic [2:0]   flg;   // [2]=all00 [1]=allff [0]=uncor
        logic [3:0]   cnt;
        logic [10:0]  len;
        logic [255:0] words; // word k at bits 32k+31:32k
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 4'd1,  11'd512, {224'h0, 32'h0000_0000}},
        '{3'b000, 4'd2,  11'd512, {224'h0, 32'h0064_0009}},
        '{3'b000, 4'd3,  11'd512, {192'h0, 32'h9388_8021, 32'h0FFF_0007}},
        '{3'b000, 4'd2,  11'd64,  {224'h0, 32'h0258_01FF}},
        '{3'b000, 4'd15, 11'd512, {32'hFFFF_0005, 32'h0010_0011, 32'h0800_0FF8, 32'h0002_0002,
                                   32'h1FFF_0FFF, 32'h01FF_0100, 32'h0001_0002, 32'h0ABC_1234}},
        '{3'b100, 4'd3,  11'd512, {224'h0, 32'h0001_0002}},
        '{3'b010, 4'd3,  11'd512, {224'h0, 32'h0001_0002}},
        '{3'b001, 4'd2,  11'd512, {224'h0, 32'h0001_0002}},
        '{3'b011, 4'd2,  11'd512, {224'h0, 32'h0001_0002}},
        '{3'b000, 4'd0,  11'd512, {224'h0, 32'h0001_0002}}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  err_count = '0;
    logic        flag_all00 = 1'b0;
    logic        flag_allff = 1'b0;
    logic        flag_uncor = 1'b0;
    logic [10:0] data_len = '0;
    logic        idx_rd_en;
    logic [2:0]  idx_rd_addr;
    logic [31:0] idx_rd_data = '0;
    logic        buf_req;
    logic        buf_we;
    logic [9:0]  buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = '0;
    logic        buf_ack = 1'b0;
    logic        done;
    logic        bad_msg;

    bch_bitfix u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .err_count (err_count),
        .flag_all00 (flag_all00), .flag_allff (flag_allff), .flag_uncor (flag_uncor),
        .data_len (data_len), .idx_rd_en (idx_rd_en), .idx_rd_addr (idx_rd_addr),
        .idx_rd_data (idx_rd_data), .buf_req (buf_req), .buf_we (buf_we),
        .buf_addr (buf_addr), .buf_wdata (buf_wdata), .buf_rdata (buf_rdata),
        .buf_ack (buf_ack), .done (done), .bad_msg (bad_msg)
    );

    always #5 clk = ~clk;

    logic [7:0]  mem     [1024];
    logic [7:0]  ref_mem [1024];
    logic [31:0] idx_mem [8];
    int n_chk = 0, n_fail = 0;
    int ack_dly = 0, wait_cnt = 0;
    int rd_cnt = 0, wr_cnt = 0, idx_cnt = 0, order_err = 0;
    logic        last_was_rd = 1'b0;
    logic [9:0]  last_rd_addr = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Buffer and index memory models, responding away from the active edge.
    task automatic responder();
        forever begin
            @(negedge clk);
            if (idx_rd_en) begin
                idx_rd_data = idx_mem[idx_rd_addr];
                idx_cnt++;
            end
            if (buf_ack) begin
                buf_ack = 1'b0;
            end else if (buf_req) begin
                if (wait_cnt < ack_dly) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    buf_ack  = 1'b1;
                    if (buf_we) begin
                        if (!last_was_rd || buf_addr != last_rd_addr) order_err++;
                        mem[buf_addr] = buf_wdata;
                        wr_cnt++;
                        last_was_rd = 1'b0;
                    end else begin
                        if (last_was_rd) order_err++;
                        buf_rdata    = mem[buf_addr];
                        last_rd_addr = buf_addr;
                        last_was_rd  = 1'b1;
                        rd_cnt++;
                    end
                end
            end
        end
    endtask

    task automatic fill_buffers();
        for (int a = 0; a < 1024; a++) begin
            mem[a]     = 8'((a * 7 + 3) & 255);
            ref_mem[a] = 8'((a * 7 + 3) & 255);
        end
        rd_cnt = 0; wr_cnt = 0; idx_cnt = 0; order_err = 0; last_was_rd = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int dly);
        int exp_acc, exp_idx, mism, guard, p;
        logic skip, exp_bad;
        logic [31:0] w;
        fill_buffers();
        ack_dly = dly;
        for (int k = 0; k < 8; k++) idx_mem[k] = v.words[32*k +: 32];
        skip    = (v.flg != 3'b000) || (v.cnt == 4'd0);
        exp_bad = v.flg[0] && !v.flg[1] && !v.flg[2];
        exp_acc = 0;
        exp_idx = skip ? 0 : (int'(v.cnt) + 1) / 2;
        if (!skip) begin
            for (int i = 0; i < int'(v.cnt); i++) begin
                w = idx_mem[i / 2];
                p = (i % 2 == 1) ? int'(w[28:16]) : int'(w[12:0]);
                if ((p >> 3) < int'(v.len)) begin
                    ref_mem[p >> 3] = ref_mem[p >> 3] ^ (8'h01 << (p % 8));
                    exp_acc++;
                end
            end
        end
        @(negedge clk);
        start = 1'b1; err_count = v.cnt; data_len = v.len;
        flag_all00 = v.flg[2]; flag_allff = v.flg[1]; flag_uncor = v.flg[0];
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk("R3,R7 done reached", 64'(done), 64'd1);
        chk("R5,R6,R10 bad_msg", 64'(bad_msg), 64'(exp_bad));
        mism = 0;
        for (int a = 0; a < 1024; a++) if (mem[a] !== ref_mem[a]) mism++;
        chk("R1,R3,R4,R9 buffer contents mismatches", 64'(mism), 64'd0);
        chk("R5,R6,R9 buffer reads", 64'(rd_cnt), 64'(exp_acc));
        chk("R8 buffer writes", 64'(wr_cnt), 64'(exp_acc));
        chk("R2 index reads", 64'(idx_cnt), 64'(exp_idx));
        chk("R8 read-then-write order errors", 64'(order_err), 64'd0);
        @(negedge clk);
        chk("R10 done single pulse", 64'(done), 64'd0);
    endtask

    initial begin
        fork responder(); join_none
        fill_buffers();
        repeat (3) @(negedge clk);
        chk("R11 done in reset", 64'(done), 64'd0);
        chk("R11 buf_req in reset", 64'(buf_req), 64'd0);
        chk("R11 idx_rd_en in reset", 64'(idx_rd_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi % 3);

        // R7: zero count gives done on the first edge after start.
        fill_buffers();
        @(negedge clk);
        start = 1'b1; err_count = 4'd0; data_len = 11'd512;
        flag_all00 = 1'b0; flag_allff = 1'b0; flag_uncor = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk("R7 done one cycle after start", 64'(done), 64'd1);
        chk("R7 bad_msg on zero count", 64'(bad_msg), 64'd0);
        @(negedge clk);
        chk("R7 no access on zero count", 64'(rd_cnt + wr_cnt + idx_cnt), 64'd0);

        // R8: slow acknowledge holds the request; ordering still read then write.
        run_vec(VECS[1], 4);
        chk("R8 slow ack buffer untouched beyond flips", 64'(order_err), 64'd0);

        // R5: blank flag with uncorrectable flag still reports success.
        run_vec(VECS[8], 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule